// File: doc/BRIEF.md
# External Bus Idle-Cycle Controller

This block sits between an internal access source and the external bus of a chip with four chip-select areas. It accepts one access at a time through a valid/ready handshake. An access names an area, a direction and an address. One clock after acceptance the block drives a single-cycle bus cycle with the chip-select of that area asserted, low active. It also reports whether that area is 8 or 16 bits wide.

The block leaves idle cycles between two bus cycles when a slow read buffer could collide with the next driver. This happens when a read is followed by an access to a different area, or when a read is followed by a write. The number of idle cycles comes from a 2-bit code held for the area of the earlier access. A 16-bit timing register holds the four codes in its upper byte. Its lower byte holds chip-select extension and setup fields that are stored and read back but have no effect here. A 4-bit width register holds the bus size for each area. A mode input can hand the size of area 0 to a pin instead.

Two resets are provided. The power-on reset restores both registers and clears the sequencing history. The synchronous manual reset clears only the history. A standby-entry pulse restores the timing register.

Top module: `bus_idle_ctrl`

## Requirements
- R1: An access accepted on a clock edge (req_valid_i and req_ready_o both high) produces, in the following cycle only, bus_active_o=1, bus_cs_n_o low on bit `area` alone, and bus_addr_o and bus_wr_o equal to the request. At most one chip-select is low at any time.
- R2: The timing register reads back on timing_q_o. It becomes 0xFFFF on power-on reset and on the edge after stby_i is high. It takes the full 16-bit cfg_wdata_i when cfg_we_i=1 and cfg_sel_i=0.
- R3: After a read to area A, an access to another area starts only after N idle cycles, where N is the code of area A. The code of area a is timing_q_o[9+2a:8+2a], and code values 0..3 mean 0..3 idle cycles.
- R4: After a read, a write to the same area also waits N idle cycles, with N the code of that area.
- R5: The idle count always comes from the code of the earlier access's area, never from the new access's area.
- R6: After a write, any access follows with no idle cycle. A read followed by a read to the same area also follows with no idle cycle.
- R7: The width register is written from cfg_wdata_i[3:0] when cfg_we_i=1 and cfg_sel_i=1. Bit a gives area a, with 1 meaning 16 bits. The register resets to 4'b1111. area_wide_o shows the effective width of each area, and bus_wide_o shows the width of the area of the current bus cycle.
- R8: With rom_off_i=1, the width of area 0 equals boot_wide_i, and width register bit 0 has no effect.
- R9: During idle cycles all chip-selects are high and bus_active_o is 0. req_ready_o is low while a pending request still owes idle cycles.
- R10: After power-on reset or manual reset the history is empty, so the first access is accepted without waiting. A manual reset leaves both registers unchanged.
- R11: A code of 0 inserts no idle cycle, even after a read to another area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Power-on reset, asynchronous, low active |
| man_rst_i | input | 1 | Manual reset, synchronous; clears history only |
| stby_i | input | 1 | Standby entry; restores timing register |
| rom_off_i | input | 1 | 1: area 0 width taken from boot_wide_i |
| boot_wide_i | input | 1 | Mode pin width for area 0 (1 = 16 bits) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0: timing register, 1: width register |
| cfg_wdata_i | input | 16 | Register write data |
| timing_q_o | output | 16 | Timing register readback |
| width_q_o | output | 4 | Width register readback |
| area_wide_o | output | 4 | Effective width per area |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_area_i | input | 2 | Target area |
| req_wr_i | input | 1 | 1: write, 0: read |
| req_addr_i | input | 24 | Access address |
| bus_active_o | output | 1 | Bus cycle in progress |
| bus_cs_n_o | output | 4 | Chip-selects, low active |
| bus_addr_o | output | 24 | Bus address |
| bus_wr_o | output | 1 | Bus direction, 1 = write |
| bus_wide_o | output | 1 | Width of current cycle, 1 = 16 bits |

## Verification
A wrong remaining-idle count or a stale record of the last access shows up at the second bus cycle of a pair. The gap between the two chip-select pulses comes out shorter or longer than the earlier area's code, so the error is visible within four cycles of the first access. A history that survives a reset shows as a stall on the first request after it. A corrupted register shows on timing_q_o or width_q_o at once, and on the next bus cycle's gap or width.

// File: rtl/bic_pkg.sv
package bic_pkg;

   typedef enum logic {
      CFG_TIMING = 1'b0,
      CFG_WIDTH  = 1'b1
   } cfg_sel_e;

   // An access that follows a read must wait when it changes area or turns the bus to a write.
   function automatic logic gap_needed(input logic last_vld,
                                       input logic last_rd,
                                       input logic same_area,
                                       input logic next_wr);
      return last_vld && last_rd && (!same_area || next_wr);
   endfunction

endpackage

// File: rtl/bic_regs.sv
module bic_regs #(
   parameter int CTRL_W = 16,
   parameter int AREAS  = 4,
   parameter int CODE_W = 2,
   localparam int CODES_W  = AREAS * CODE_W,
   localparam int CODE_LSB = CTRL_W - CODES_W
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              stby_i,
   input  logic              cfg_we_i,
   input  logic              cfg_sel_i,
   input  logic [CTRL_W-1:0] cfg_wdata_i,
   output logic [CTRL_W-1:0] timing_q_o,
   output logic [AREAS-1:0]  width_q_o,
   output logic [CODES_W-1:0] codes_o
);
   import bic_pkg::*;

   if (CTRL_W < CODES_W) begin : g_bad_ctrl
      $error("bic_regs: CTRL_W too small for the idle codes");
   end
   if (CTRL_W < AREAS) begin : g_bad_width
      $error("bic_regs: CTRL_W narrower than the width register");
   end

   cfg_sel_e    sel;
   logic        wr_timing;
   logic        wr_width;

   assign sel       = cfg_sel_e'(cfg_sel_i);
   assign wr_timing = cfg_we_i && (sel == CFG_TIMING);
   assign wr_width  = cfg_we_i && (sel == CFG_WIDTH);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         timing_q_o <= '1;
      end else if (stby_i) begin
         timing_q_o <= '1;
      end else if (wr_timing) begin
         timing_q_o <= cfg_wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         width_q_o <= '1;
      end else if (wr_width) begin
         width_q_o <= cfg_wdata_i[AREAS-1:0];
      end
   end

   assign codes_o = timing_q_o[CODE_LSB +: CODES_W];

endmodule

// File: rtl/bic_wsel.sv
module bic_wsel #(
   parameter int AREAS = 4
) (
   input  logic [AREAS-1:0] width_q_i,
   input  logic             rom_off_i,
   input  logic             boot_wide_i,
   output logic [AREAS-1:0] area_wide_o
);
   for (genvar g = 0; g < AREAS; g++) begin : g_area
      if (g == 0) begin : g_boot
         assign area_wide_o[g] = rom_off_i ? boot_wide_i : width_q_i[g];
      end else begin : g_plain
         assign area_wide_o[g] = width_q_i[g];
      end
   end
endmodule

// File: rtl/bic_gap.sv
module bic_gap #(
   parameter int AREAS  = 4,
   parameter int CODE_W = 2,
   localparam int AREA_W  = (AREAS > 1) ? $clog2(AREAS) : 1,
   localparam int CODES_W = AREAS * CODE_W
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               man_rst_i,
   input  logic               accept_i,
   input  logic [AREA_W-1:0]  req_area_i,
   input  logic               req_wr_i,
   input  logic [CODES_W-1:0] codes_i,
   output logic               ready_o
);
   import bic_pkg::*;

   logic              last_vld_q;
   logic              last_rd_q;
   logic [AREA_W-1:0] last_area_q;
   logic [CODE_W-1:0] hold_q;
   logic [CODE_W-1:0] req_code;
   logic              must_wait;

   assign req_code  = codes_i[req_area_i * CODE_W +: CODE_W];
   assign must_wait = gap_needed(last_vld_q, last_rd_q, (req_area_i == last_area_q), req_wr_i);
   assign ready_o   = !(must_wait && (hold_q != '0));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         last_vld_q  <= 1'b0;
         last_rd_q   <= 1'b0;
         last_area_q <= '0;
         hold_q      <= '0;
      end else if (man_rst_i) begin
         last_vld_q  <= 1'b0;
         last_rd_q   <= 1'b0;
         last_area_q <= '0;
         hold_q      <= '0;
      end else if (accept_i) begin
         last_vld_q  <= 1'b1;
         last_rd_q   <= !req_wr_i;
         last_area_q <= req_area_i;
         hold_q      <= req_wr_i ? '0 : req_code;
      end else if (hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
      end
   end
endmodule

// File: rtl/bic_issue.sv
module bic_issue #(
   parameter int AREAS  = 4,
   parameter int ADDR_W = 24,
   localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              man_rst_i,
   input  logic              accept_i,
   input  logic [AREA_W-1:0] req_area_i,
   input  logic              req_wr_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [AREAS-1:0]  area_wide_i,
   output logic              bus_active_o,
   output logic [AREAS-1:0]  bus_cs_n_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_wr_o,
   output logic              bus_wide_o
);
   logic              go;
   logic [AREAS-1:0]  sel_d;

   assign go = accept_i && !man_rst_i;

   for (genvar g = 0; g < AREAS; g++) begin : g_cs
      assign sel_d[g] = go && (req_area_i == AREA_W'(g));
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            bus_cs_n_o[g] <= 1'b1;
         end else begin
            bus_cs_n_o[g] <= !sel_d[g];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         bus_active_o <= 1'b0;
         bus_addr_o   <= '0;
         bus_wr_o     <= 1'b0;
         bus_wide_o   <= 1'b0;
      end else begin
         bus_active_o <= go;
         if (go) begin
            bus_addr_o <= req_addr_i;
            bus_wr_o   <= req_wr_i;
            bus_wide_o <= area_wide_i[req_area_i];
         end
      end
   end
endmodule

// File: rtl/bus_idle_ctrl.sv
module bus_idle_ctrl #(
   parameter int AREAS  = 4,
   parameter int CODE_W = 2,
   parameter int CTRL_W = 16,
   parameter int ADDR_W = 24,
   localparam int AREA_W  = (AREAS > 1) ? $clog2(AREAS) : 1,
   localparam int CODES_W = AREAS * CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              man_rst_i,
   input  logic              stby_i,
   input  logic              rom_off_i,
   input  logic              boot_wide_i,
   input  logic              cfg_we_i,
   input  logic              cfg_sel_i,
   input  logic [CTRL_W-1:0] cfg_wdata_i,
   output logic [CTRL_W-1:0] timing_q_o,
   output logic [AREAS-1:0]  width_q_o,
   output logic [AREAS-1:0]  area_wide_o,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [AREA_W-1:0] req_area_i,
   input  logic              req_wr_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              bus_active_o,
   output logic [AREAS-1:0]  bus_cs_n_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_wr_o,
   output logic              bus_wide_o
);
   if (AREAS < 2 || (1 << AREA_W) != AREAS) begin : g_bad_areas
      $error("bus_idle_ctrl: AREAS must be a power of two, at least 2");
   end
   if (CODE_W < 1 || ADDR_W < 1) begin : g_bad_fields
      $error("bus_idle_ctrl: CODE_W and ADDR_W must be positive");
   end

   logic [CODES_W-1:0] codes;
   logic               accept;

   assign accept = req_valid_i && req_ready_o;

   bic_regs #(.CTRL_W(CTRL_W), .AREAS(AREAS), .CODE_W(CODE_W)) u_regs (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .stby_i      (stby_i),
      .cfg_we_i    (cfg_we_i),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_wdata_i (cfg_wdata_i),
      .timing_q_o  (timing_q_o),
      .width_q_o   (width_q_o),
      .codes_o     (codes)
   );

   bic_wsel #(.AREAS(AREAS)) u_wsel (
      .width_q_i   (width_q_o),
      .rom_off_i   (rom_off_i),
      .boot_wide_i (boot_wide_i),
      .area_wide_o (area_wide_o)
   );

   bic_gap #(.AREAS(AREAS), .CODE_W(CODE_W)) u_gap (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .man_rst_i  (man_rst_i),
      .accept_i   (accept),
      .req_area_i (req_area_i),
      .req_wr_i   (req_wr_i),
      .codes_i    (codes),
      .ready_o    (req_ready_o)
   );

   bic_issue #(.AREAS(AREAS), .ADDR_W(ADDR_W)) u_issue (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .man_rst_i    (man_rst_i),
      .accept_i     (accept),
      .req_area_i   (req_area_i),
      .req_wr_i     (req_wr_i),
      .req_addr_i   (req_addr_i),
      .area_wide_i  (area_wide_o),
      .bus_active_o (bus_active_o),
      .bus_cs_n_o   (bus_cs_n_o),
      .bus_addr_o   (bus_addr_o),
      .bus_wr_o     (bus_wr_o),
      .bus_wide_o   (bus_wide_o)
   );
endmodule

// File: rtl/bic_chk.sv
module bic_chk #(
   parameter int AREAS  = 4,
   parameter int CODE_W = 2,
   parameter int CTRL_W = 16,
   localparam int AREA_W   = (AREAS > 1) ? $clog2(AREAS) : 1,
   localparam int CODE_LSB = CTRL_W - AREAS * CODE_W
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              man_rst_i,
   input logic              stby_i,
   input logic              rom_off_i,
   input logic              boot_wide_i,
   input logic [CTRL_W-1:0] timing_q_o,
   input logic [AREAS-1:0]  area_wide_o,
   input logic              req_valid_i,
   input logic              req_ready_o,
   input logic [AREA_W-1:0] req_area_i,
   input logic              req_wr_i,
   input logic              bus_active_o,
   input logic [AREAS-1:0]  bus_cs_n_o
);
   logic              acc;
   logic [CODE_W-1:0] req_code;

   assign acc      = req_valid_i && req_ready_o;
   assign req_code = timing_q_o[CODE_LSB + req_area_i * CODE_W +: CODE_W];

   AST_BUS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (acc && !man_rst_i) |=> (bus_active_o && !bus_cs_n_o[$past(req_area_i)])); // R1
   AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $onehot0(~bus_cs_n_o)); // R1
   AST_STBY_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      stby_i |=> (timing_q_o == '1)); // R2
   AST_XAREA_WAIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (acc && !req_wr_i && req_code != '0 && !man_rst_i) |=>
      !(req_valid_i && req_ready_o && req_area_i != $past(req_area_i))); // R3
   AST_TURN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (acc && !req_wr_i && req_code != '0 && !man_rst_i) |=> !(req_valid_i && req_ready_o && req_wr_i)); // R4
   AST_WRITE_FREE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (acc && req_wr_i) |=> req_ready_o); // R6
   AST_ROM_OFF_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rom_off_i |-> (area_wide_o[0] == boot_wide_i)); // R8
   AST_IDLE_CS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !bus_active_o |-> (&bus_cs_n_o)); // R9
endmodule

bind bus_idle_ctrl bic_chk #(.AREAS(AREAS), .CODE_W(CODE_W), .CTRL_W(CTRL_W)) u_chk (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .man_rst_i    (man_rst_i),
   .stby_i       (stby_i),
   .rom_off_i    (rom_off_i),
   .boot_wide_i  (boot_wide_i),
   .timing_q_o   (timing_q_o),
   .area_wide_o  (area_wide_o),
   .req_valid_i  (req_valid_i),
   .req_ready_o  (req_ready_o),
   .req_area_i   (req_area_i),
   .req_wr_i     (req_wr_i),
   .bus_active_o (bus_active_o),
   .bus_cs_n_o   (bus_cs_n_o)
);

// File: tb/bus_idle_ctrl_tb.sv
`timescale 1ns/1ps
module bus_idle_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        man_rst = 1'b0, stby = 1'b0, rom_off = 1'b0, boot_wide = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] timing_q;
   logic [3:0]  width_q, area_wide;
   logic        req_valid = 1'b0, req_ready, req_wr = 1'b0;
   logic [1:0]  req_area = '0;
   logic [23:0] req_addr = '0;
   logic        bus_active, bus_wr, bus_wide;
   logic [3:0]  bus_cs_n;
   logic [23:0] bus_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [1:0]  area;
      logic        wr;
      logic [23:0] addr;
      logic        wide;
      int          gap;
      int          tag;
   } item_t;
   item_t exp_q[$];

   logic [3:0] m_width = 4'hF;

   always #2.5 clk = ~clk;

   bus_idle_ctrl u_dut (
      .clk_i(clk), .rst_n_i(rst_n), .man_rst_i(man_rst), .stby_i(stby),
      .rom_off_i(rom_off), .boot_wide_i(boot_wide),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
      .timing_q_o(timing_q), .width_q_o(width_q), .area_wide_o(area_wide),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_area_i(req_area),
      .req_wr_i(req_wr), .req_addr_i(req_addr),
      .bus_active_o(bus_active), .bus_cs_n_o(bus_cs_n), .bus_addr_o(bus_addr),
      .bus_wr_o(bus_wr), .bus_wide_o(bus_wide)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_wide(input logic [1:0] a);
      if (a == 2'd0 && rom_off) return boot_wide;
      return m_width[a];
   endfunction

   // Driver: present the request, push the expected bus item, return cycles spent waiting.
   task automatic send(input logic [1:0] a, input logic wr, input logic [23:0] ad,
                       input int gap, input int tag, output int waits);
      item_t it;
      @(negedge clk);
      req_valid = 1'b1; req_area = a; req_wr = wr; req_addr = ad;
      it.area = a; it.wr = wr; it.addr = ad; it.wide = exp_wide(a); it.gap = gap; it.tag = tag;
      exp_q.push_back(it);
      waits = 0;
      #0.5;
      while (!req_ready) begin
         @(negedge clk);
         #0.5;
         waits++;
      end
      @(posedge clk);
   endtask

   task automatic drop();
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic cfg_write(input logic sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      if (sel) m_width = d[3:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Monitor: pop and compare each bus cycle, including the idle run before it.
   initial begin
      int idle_run = 0;
      item_t it;
      forever begin
         @(negedge clk);
         if (rst_n && bus_active) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected bus cycle", bus_addr, 0);
            end else begin
               it = exp_q.pop_front();
               check(bus_cs_n == ~(4'b0001 << it.area), $sformatf("R1/R%0d", it.tag), "cs_n",
                     bus_cs_n, ~(4'b0001 << it.area));
               check(bus_addr == it.addr && bus_wr == it.wr, "R1", "addr/dir",
                     {bus_wr, bus_addr}, {it.wr, it.addr});
               check(bus_wide == it.wide, "R7", "bus width", bus_wide, it.wide);
               if (it.gap >= 0)
                  check(idle_run == it.gap, $sformatf("R%0d", it.tag), "idle cycles",
                        idle_run, it.gap);
            end
            idle_run = 0;
         end else begin
            if (rst_n) check(bus_cs_n == 4'hF, "R9", "cs high while idle", bus_cs_n, 4'hF);
            idle_run++;
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         finish_run();
      end
   end

   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(timing_q == 16'hFFFF, "R2", "timing reset", timing_q, 16'hFFFF);
      check(width_q == 4'hF && area_wide == 4'hF, "R7", "width reset", {width_q, area_wide}, 8'hFF);
      check(!bus_active && bus_cs_n == 4'hF, "R9", "bus idle after reset", {bus_active, bus_cs_n}, 5'h0F);

      // Default codes are all 3.
      send(2'd1, 1'b0, 24'h000100, -1, 10, w);
      check(w == 0, "R10", "first access waits", w, 0);
      send(2'd1, 1'b0, 24'h000104, 0, 6, w);   // R6 read then same-area read
      send(2'd2, 1'b0, 24'h000200, 3, 3, w);   // R3 area change after read
      send(2'd2, 1'b1, 24'h000204, 3, 4, w);   // R4 read then write, same area
      send(2'd0, 1'b1, 24'h000000, 0, 6, w);   // R6 write then anything
      drop();

      // Codes: area3=0, area2=1, area1=2, area0=3; low byte stored only.
      cfg_write(1'b0, 16'h1B5A);
      check(timing_q == 16'h1B5A, "R2", "timing write readback", timing_q, 16'h1B5A);
      send(2'd0, 1'b0, 24'h000010, -1, 5, w);
      send(2'd1, 1'b0, 24'h000110, 3, 5, w);   // R5 code of area 0
      send(2'd0, 1'b0, 24'h000014, 2, 5, w);   // R5 code of area 1
      send(2'd2, 1'b0, 24'h000210, 3, 3, w);   // R3
      send(2'd3, 1'b0, 24'h000310, 1, 3, w);   // R3 code of area 2
      send(2'd0, 1'b0, 24'h000018, 0, 11, w);  // R11 area 3 code 0
      send(2'd0, 1'b1, 24'h00001C, 3, 4, w);   // R4
      drop();

      // Widths: area0 16, area1 8, area2 16, area3 8.
      cfg_write(1'b1, 16'h0005);
      check(width_q == 4'h5 && area_wide == 4'h5, "R7", "width write", {width_q, area_wide}, 8'h55);
      send(2'd1, 1'b1, 24'h000120, -1, 7, w);
      send(2'd2, 1'b1, 24'h000220, 0, 7, w);
      send(2'd0, 1'b1, 24'h000020, 0, 7, w);
      drop();
      rom_off = 1'b1; boot_wide = 1'b0;
      #1;
      check(area_wide == 4'h4, "R8", "area0 from pin (0)", area_wide, 4'h4);
      send(2'd0, 1'b1, 24'h000024, -1, 8, w);  // R8 bus_wide 0 although register bit is 1
      drop();
      boot_wide = 1'b1;
      cfg_write(1'b1, 16'h0004);
      check(area_wide == 4'h5, "R8", "register bit 0 ignored", area_wide, 4'h5);
      rom_off = 1'b0;
      cfg_write(1'b1, 16'h000F);

      // Manual reset clears the history but not the registers.
      send(2'd1, 1'b0, 24'h000130, -1, 10, w);
      @(negedge clk);
      req_valid = 1'b0; man_rst = 1'b1;
      @(negedge clk);
      man_rst = 1'b0;
      check(timing_q == 16'h1B5A && width_q == 4'hF, "R10", "registers kept",
            {timing_q, width_q}, {16'h1B5A, 4'hF});
      exp_q.push_back('{area: 2'd2, wr: 1'b1, addr: 24'h000230, wide: 1'b1, gap: -1, tag: 10});
      req_valid = 1'b1; req_area = 2'd2; req_wr = 1'b1; req_addr = 24'h000230;
      #0.5;
      check(req_ready == 1'b1, "R10", "no wait after manual reset", req_ready, 1);
      @(posedge clk);
      drop();

      // Standby restores the timing register.
      @(negedge clk); stby = 1'b1;
      @(negedge clk); stby = 1'b0;
      check(timing_q == 16'hFFFF, "R2", "standby restore", timing_q, 16'hFFFF);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R1", "all expected cycles seen", exp_q.size(), 0);
      done = 1'b1;
      finish_run();
   end
endmodule